// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Code Register Bank

This block sits on a simple synchronous register bus and supplies four 12-bit conversion codes, plus a polarity bit and a gain bit per channel, to an analog output stage. The host writes codes and range settings into holding registers. They reach the outputs only when the host reads one of two strobe addresses. This lets every channel change on the same clock edge. One strobe read commits all four codes, and a second strobe read commits the range settings.

A small control register sets whether the outputs are enabled and whether code writes are buffered. With buffering off, a code write goes straight to the output. With the enable clear, the code outputs are held at zero, but the active registers keep tracking the writes. Every bus access completes in one cycle, and each access is either a read or a write. All addresses are byte offsets, and channel 0 is channel A.

Top module: `dac_update_bank`

## Requirements
- R1: After reset, the control register, the range holding and active registers, and all code holding and active registers are zero. If the outputs are then enabled without any code write, every code reads zero.
- R2: A write to offset 0x02 sets the output enable from bit 1 and buffered mode from bit 0. All other data bits are ignored.
- R3: A write to offset 0x14 + 2*ch (ch 0..3 = A..D) stores bits [11:0] of the data in that channel's code holding register. Bits [15:12] are ignored.
- R4: In buffered mode (bit 0 = 1), a code write leaves every code output unchanged.
- R5: A read of offset 0x02 copies all four code holding registers to the active codes on the same edge. The new codes appear on the cycle after the read.
- R6: With buffered mode off, a code write updates that channel's active code on the write's edge.
- R7: While the enable bit is 0, all four code outputs are zero. The range outputs are not affected by the enable bit.
- R8: A write to offset 0x12 is held, and the polarity and gain outputs do not change until the commit read.
- R9: A read of offset 0x12 commits the held range settings. Polarity (1 = bipolar) comes from bits 7, 6, 5, 4 for A, B, C, D. Gain comes from bits 11, 10, 9, 8 for A, B, C, D.
- R10: Reads and writes at any other offset have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| dac_code | output | 48 | Active codes; channel ch at bits [12*ch +: 12] |
| dac_bipolar | output | 4 | Active polarity per channel, bit ch = channel ch |
| dac_gain | output | 4 | Active gain per channel, bit ch = channel ch |

## Verification
Every result of an access is registered once. A write or strobe read that is presented before a rising edge therefore shows its effect after that edge and is due one cycle later. The control bits take effect at that same edge, so the enable gating is due in the same cycle as any code change. The bench drives each access on a falling edge and samples on the next falling edge, exactly one rising edge later. Every vector in the table also samples the outputs that should not move. After reset is released, the bench waits out the two-stage release synchronizer before its first check.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int unsigned CH_N    = 4;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ADDR_W  = 8;
  localparam logic [7:0] OFF_CTRL = 8'h02;
  localparam logic [7:0] OFF_CFG  = 8'h12;
  localparam logic [7:0] OFF_CODE = 8'h14;
  localparam int unsigned POL_MSB  = 7;
  localparam int unsigned GAIN_MSB = 11;
  localparam int unsigned EN_BIT   = 1;
  localparam int unsigned BUF_BIT  = 0;
endpackage

// File: rtl/dacbank_rstsync.sv
module dacbank_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dacbank_decode.sv
module dacbank_decode #(
  parameter int unsigned ADDR_W   = dacbank_pkg::ADDR_W,
  parameter int unsigned CH_N     = dacbank_pkg::CH_N,
  parameter logic [7:0]  OFF_CTRL = dacbank_pkg::OFF_CTRL,
  parameter logic [7:0]  OFF_CFG  = dacbank_pkg::OFF_CFG,
  parameter logic [7:0]  OFF_CODE = dacbank_pkg::OFF_CODE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_ctrl,
  output logic              wr_cfg,
  output logic              rd_cfg,
  output logic              rd_upd,
  output logic [CH_N-1:0]   wr_code
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign rd_upd  = rd && (addr == A_CTRL);
  assign wr_cfg  = wr && (addr == A_CFG);
  assign rd_cfg  = rd && (addr == A_CFG);

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_sel
    localparam logic [ADDR_W-1:0] A_CH = ADDR_W'(OFF_CODE + 8'(2 * ch));
    assign wr_code[ch] = wr && (addr == A_CH);
  end
endmodule

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl #(
  parameter int unsigned CH_N     = dacbank_pkg::CH_N,
  parameter int unsigned DATA_W   = dacbank_pkg::DATA_W,
  parameter int unsigned POL_MSB  = dacbank_pkg::POL_MSB,
  parameter int unsigned GAIN_MSB = dacbank_pkg::GAIN_MSB,
  parameter int unsigned EN_BIT   = dacbank_pkg::EN_BIT,
  parameter int unsigned BUF_BIT  = dacbank_pkg::BUF_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cfg,
  input  logic              rd_cfg,
  input  logic [DATA_W-1:0] wdata,
  output logic              enable,
  output logic              buffered,
  output logic [CH_N-1:0]   bipolar,
  output logic [CH_N-1:0]   gain
);
  localparam int unsigned RW = 2 * CH_N;

  logic          en_q, en_d, buf_q, buf_d;
  logic [RW-1:0] hold_q, hold_d, act_q, act_d;
  logic [RW-1:0] wr_range;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_map
    assign wr_range[ch]        = wdata[POL_MSB - ch];
    assign wr_range[CH_N + ch] = wdata[GAIN_MSB - ch];
  end

  always_comb begin
    en_d   = en_q;
    buf_d  = buf_q;
    hold_d = hold_q;
    act_d  = act_q;
    if (wr_ctrl) begin
      en_d  = wdata[EN_BIT];
      buf_d = wdata[BUF_BIT];
    end
    if (wr_cfg) hold_d = wr_range;
    if (rd_cfg) act_d  = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      buf_q  <= 1'b0;
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= en_d;
        buf_q <= buf_d;
      end
      if (wr_cfg) hold_q <= hold_d;
      if (rd_cfg) act_q  <= act_d;
    end
  end

  assign enable   = en_q;
  assign buffered = buf_q;
  assign bipolar  = act_q[CH_N-1:0];
  assign gain     = act_q[RW-1:CH_N];

  p_range_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cfg |=> $stable({bipolar, gain}));

  p_range_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cfg && !wr_cfg) |=> ({gain, bipolar} == $past(hold_q)));
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int unsigned CODE_W = dacbank_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              upd,
  input  logic              buffered,
  input  logic              enable,
  input  logic [CODE_W-1:0] wcode,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] hold_q, hold_d, act_q, act_d;
  logic              hold_en, act_en;

  always_comb begin
    hold_en = wr_sel;
    act_en  = upd || (wr_sel && !buffered);
    hold_d  = wcode;
    act_d   = (wr_sel && !buffered) ? wcode : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (act_en)  act_q  <= act_d;
    end
  end

  assign code_o = enable ? act_q : '0;

  p_buffered_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !upd) |=> $stable(act_q));

  p_update_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !wr_sel) |=> (act_q == $past(hold_q)));

  p_direct_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !buffered) |=> (act_q == $past(wcode)));
endmodule

// File: rtl/dac_update_bank.sv
module dac_update_bank #(
  parameter int unsigned CH_N   = dacbank_pkg::CH_N,
  parameter int unsigned CODE_W = dacbank_pkg::CODE_W,
  parameter int unsigned DATA_W = dacbank_pkg::DATA_W,
  parameter int unsigned ADDR_W = dacbank_pkg::ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [CH_N*CODE_W-1:0]   dac_code,
  output logic [CH_N-1:0]          dac_bipolar,
  output logic [CH_N-1:0]          dac_gain
);
  logic            rst_ni;
  logic            wr_ctrl, wr_cfg, rd_cfg, rd_upd;
  logic [CH_N-1:0] wr_code;
  logic            enable, buffered;

  dacbank_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  dacbank_decode #(.ADDR_W(ADDR_W), .CH_N(CH_N)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg), .rd_cfg(rd_cfg),
    .rd_upd(rd_upd), .wr_code(wr_code)
  );

  dacbank_ctrl #(.CH_N(CH_N), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg),
    .rd_cfg(rd_cfg), .wdata(bus_wdata), .enable(enable),
    .buffered(buffered), .bipolar(dac_bipolar), .gain(dac_gain)
  );

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    dacbank_chan #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst_n(rst_ni), .wr_sel(wr_code[ch]), .upd(rd_upd),
      .buffered(buffered), .enable(enable),
      .wcode(bus_wdata[CODE_W-1:0]),
      .code_o(dac_code[ch*CODE_W +: CODE_W])
    );
  end

  p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !enable |-> (dac_code == '0));

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_ni |-> (dac_code == '0 && dac_bipolar == '0 && dac_gain == '0));
endmodule

// File: tb/dac_update_bank_test.sv
`timescale 1ns/1ps
module dac_update_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata;
  logic [47:0] dac_code;
  logic [3:0]  dac_bipolar, dac_gain;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_update_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .dac_code(dac_code),
    .dac_bipolar(dac_bipolar), .dac_gain(dac_gain)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 idle, 1 write, 2 read
    logic [7:0]  addr;
    logic [15:0] wd;
    logic [47:0] code;
    logic [3:0]  pol;
    logic [3:0]  gain;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 8'h02, 16'h0003, 48'h000_000_000_000, 4'b0000, 4'b0000},
    '{2'd1, 8'h14, 16'hF123, 48'h000_000_000_000, 4'b0000, 4'b0000},
    '{2'd1, 8'h16, 16'h0456, 48'h000_000_000_000, 4'b0000, 4'b0000},
    '{2'd1, 8'h18, 16'h0789, 48'h000_000_000_000, 4'b0000, 4'b0000},
    '{2'd1, 8'h1A, 16'h0ABC, 48'h000_000_000_000, 4'b0000, 4'b0000},
    '{2'd2, 8'h00, 16'h0000, 48'h000_000_000_000, 4'b0000, 4'b0000},
    '{2'd2, 8'h02, 16'h0000, 48'hABC_789_456_123, 4'b0000, 4'b0000},
    '{2'd1, 8'h12, 16'h0A50, 48'hABC_789_456_123, 4'b0000, 4'b0000},
    '{2'd2, 8'h12, 16'h0000, 48'hABC_789_456_123, 4'b1010, 4'b0101},
    '{2'd1, 8'h02, 16'h0002, 48'hABC_789_456_123, 4'b1010, 4'b0101},
    '{2'd1, 8'h14, 16'h0FFF, 48'hABC_789_456_FFF, 4'b1010, 4'b0101},
    '{2'd1, 8'h1A, 16'h0001, 48'h001_789_456_FFF, 4'b1010, 4'b0101},
    '{2'd1, 8'h02, 16'hFFFC, 48'h000_000_000_000, 4'b1010, 4'b0101},
    '{2'd1, 8'h16, 16'h0222, 48'h000_000_000_000, 4'b1010, 4'b0101},
    '{2'd1, 8'h02, 16'h0002, 48'h001_789_222_FFF, 4'b1010, 4'b0101},
    '{2'd1, 8'h20, 16'h0FFF, 48'h001_789_222_FFF, 4'b1010, 4'b0101},
    '{2'd1, 8'h12, 16'h0000, 48'h001_789_222_FFF, 4'b1010, 4'b0101},
    '{2'd2, 8'h14, 16'h0000, 48'h001_789_222_FFF, 4'b1010, 4'b0101},
    '{2'd2, 8'h12, 16'h0000, 48'h001_789_222_FFF, 4'b0000, 4'b0000}
  };

  function automatic string req_of(int i);
    case (i)
      0:       return "R2";
      1:       return "R3";
      2, 3, 4: return "R4";
      5, 15, 17: return "R10";
      6:       return "R5";
      7, 16:   return "R8";
      8, 18:   return "R9";
      9, 10, 11: return "R6";
      12, 13:  return "R7";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [47:0] code, logic [3:0] pol, logic [3:0] gn);
    vectors++;
    if (dac_code !== code || dac_bipolar !== pol || dac_gain !== gn) begin
      miscompares++;
      $display("FAIL %s: code=%h pol=%b gain=%b expected code=%h pol=%b gain=%b",
               req, dac_code, dac_bipolar, dac_gain, code, pol, gn);
    end
  endtask

  task automatic bus_op(logic [1:0] op, logic [7:0] addr, logic [15:0] wd);
    @(negedge clk);
    bus_addr  = addr;
    bus_wdata = wd;
    bus_wr    = (op == 2'd1);
    bus_rd    = (op == 2'd2);
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    do_reset();
    check("R1", 48'h0, 4'b0000, 4'b0000);
    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i].op, VEC[i].addr, VEC[i].wd);
      check(req_of(i), VEC[i].code, VEC[i].pol, VEC[i].gain);
    end
    // R1: reset mid-run clears active and holding state
    do_reset();
    check("R1", 48'h0, 4'b0000, 4'b0000);
    bus_op(2'd1, 8'h02, 16'h0003);
    check("R1", 48'h0, 4'b0000, 4'b0000);
    bus_op(2'd2, 8'h02, 16'h0000);
    check("R1", 48'h0, 4'b0000, 4'b0000);
    bus_op(2'd2, 8'h12, 16'h0000);
    check("R1", 48'h0, 4'b0000, 4'b0000);
    // R3: upper data bits ignored, channel C direct write
    bus_op(2'd1, 8'h02, 16'h0002);
    bus_op(2'd1, 8'h18, 16'hA5A5);
    check("R3", 48'h000_5A5_000_000, 4'b0000, 4'b0000);
    // R5: all channels commit together in buffered mode
    bus_op(2'd1, 8'h02, 16'h0003);
    bus_op(2'd1, 8'h14, 16'h0111);
    bus_op(2'd1, 8'h1A, 16'h0444);
    check("R4", 48'h000_5A5_000_000, 4'b0000, 4'b0000);
    bus_op(2'd2, 8'h02, 16'h0000);
    check("R5", 48'h444_5A5_000_111, 4'b0000, 4'b0000);
    // R9: single channel range bits (A bipolar, D gain)
    bus_op(2'd1, 8'h12, 16'h0180);
    bus_op(2'd2, 8'h12, 16'h0000);
    check("R9", 48'h444_5A5_000_111, 4'b0001, 4'b1000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule